// File: doc/BRIEF.md
# Picture-in-picture mosaic window generator

The block watches the display raster through a horizontal pixel counter and a vertical line counter. For every pixel it decides whether the pixel lies inside one of the sub-picture windows of the main channel, inside one of the windows of the sub channel, or inside neither. Each channel places one window shape on a grid of up to four rows. Each row holds up to four copies of the window. The block then reports which channel is on top at that pixel.

Each channel has its own geometry set with the following fields:
- a coarse horizontal and vertical origin,
- the window size,
- the number of rows and the spacing between rows,
- a per-row window count, a per-row start offset and a per-row window spacing.

The geometry and the priority bit arrive on parallel ports. They take effect only when the field-start strobe is high, so a picture never tears partway through a field. All outputs are registered and follow the counters by one clock. The counters are a free-running raster, not a stream, so there is no handshake. A new pixel position is accepted every cycle.

Top module: `pip_mosaic_gen`

## Requirements
- R1: After reset all outputs are 0. No hit is reported until the first cycle with `field_start` high has loaded a geometry.
- R2: Geometry and priority ports are captured only in a cycle with `field_start` high. Changes at other times have no effect on the outputs. The capturing cycle itself is still judged with the previous geometry.
- R3: Window column c of row r spans the pixels from 4*(hstart + hoff[r] + c*hdist[r]) up to 4*(width+1) pixels, ending just before the next start. A width code of 0 gives 4 pixels.
- R4: Row r spans height+1 lines, beginning at line vstart + r*vdist. A height code of 0 gives 1 line.
- R5: A row-count code k (0..3) enables rows 0 to k. Rows above k never hit.
- R6: In the per-row count byte, bits [2r+1:2r] hold a code n that enables columns 0 to n of row r.
- R7: In the offset byte, bits [2r+1:2r] hold the start offset of row r, in 4-pixel units.
- R8: In the 32-bit spacing word, bits [8r+7:8r] set the start-to-start spacing, in 4-pixel units, between neighbouring windows of row r.
- R9: When windows of one channel overlap, the window in the lowest row wins. Within that row, the lowest column wins.
- R10: `src_sel` encodes the result as 00 = neither, 01 = main, 10 = sub. When both channels hit, a priority of 0 selects sub and a priority of 1 selects main.
- R11: `hit_row` and `hit_col` give the window of the channel named by `src_sel`. Both are 0 when `src_sel` is 00.
- R12: All outputs reflect the counter values of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | Capture strobe for geometry and priority |
| h_cnt | input | HCW | Raster pixel counter |
| v_cnt | input | VCW | Raster line counter |
| main_hstart | input | 8 | Main horizontal origin, 4-pixel units |
| main_vstart | input | 8 | Main vertical origin, lines |
| main_width | input | 8 | Main window width code |
| main_height | input | 8 | Main window height code |
| main_rows | input | 2 | Main row-count code |
| main_vdist | input | 8 | Main row spacing, lines |
| main_hrep | input | 8 | Main per-row window counts, 2 bits per row |
| main_hoff | input | 8 | Main per-row offsets, 2 bits per row |
| main_hdist | input | 32 | Main per-row window spacings, 8 bits per row |
| sub_hstart | input | 8 | Sub horizontal origin, 4-pixel units |
| sub_vstart | input | 8 | Sub vertical origin, lines |
| sub_width | input | 8 | Sub window width code |
| sub_height | input | 8 | Sub window height code |
| sub_rows | input | 2 | Sub row-count code |
| sub_vdist | input | 8 | Sub row spacing, lines |
| sub_hrep | input | 8 | Sub per-row window counts |
| sub_hoff | input | 8 | Sub per-row offsets |
| sub_hdist | input | 32 | Sub per-row window spacings |
| prio_main | input | 1 | Overlap priority, 1 = main on top |
| main_hit | output | 1 | Pixel lies in a main window |
| sub_hit | output | 1 | Pixel lies in a sub window |
| hit_row | output | 2 | Row of the selected window |
| hit_col | output | 2 | Column of the selected window |
| src_sel | output | 2 | Visible source |

## Verification
A geometry reload and a pixel evaluation can fall in the same cycle. The bench raises `field_start` together with a pixel position that only the old geometry covers. It expects that pixel to hit, and it expects the next pixel to be judged with the new geometry. The two channels also hit in the same cycle. That case is provoked by overlapping main and sub grids and is judged through `src_sel` and the reported indices under both priority settings.

// File: rtl/pip_pkg.sv
package pip_pkg;
  localparam int GRID   = 4;   // rows per channel and windows per row
  localparam int IDXW   = 2;   // width of a row or column index
  localparam int FW     = 8;   // width of one geometry field
  localparam int UNIT_SH = 2;  // horizontal unit is 4 pixels

  typedef struct packed {
    logic [FW-1:0]        hstart;
    logic [FW-1:0]        vstart;
    logic [FW-1:0]        width;
    logic [FW-1:0]        height;
    logic [IDXW-1:0]      rows;
    logic [FW-1:0]        vdist;
    logic [GRID*IDXW-1:0] hrep;
    logic [GRID*IDXW-1:0] hoff;
    logic [GRID*FW-1:0]   hdist;
  } pip_cfg_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_SUB  = 2'b10
  } pip_src_e;
endpackage

// File: rtl/pip_win_cell.sv
module pip_win_cell #(
  parameter int XW = 14
) (
  input  logic          en,
  input  logic [XW-1:0] px,
  input  logic [XW-1:0] ln,
  input  logic [XW-1:0] x0,
  input  logic [XW-1:0] y0,
  input  logic [XW-1:0] w_px,
  input  logic [XW-1:0] h_ln,
  output logic          hit
);
  logic in_x, in_y;
  always_comb begin
    in_x = (px >= x0) && (px < x0 + w_px);
    in_y = (ln >= y0) && (ln < y0 + h_ln);
    hit  = en && in_x && in_y;
  end
endmodule

// File: rtl/pip_first_set.sv
module pip_first_set #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pip_channel.sv
module pip_channel
  import pip_pkg::*;
#(
  parameter int XW = 14
) (
  input  pip_cfg_t        cfg,
  input  logic [XW-1:0]   px,
  input  logic [XW-1:0]   ln,
  output logic            hit,
  output logic [IDXW-1:0] row,
  output logic [IDXW-1:0] col
);
  localparam int NWIN = GRID * GRID;

  logic [NWIN-1:0]      cell_hit;
  logic [2*IDXW-1:0]    first;
  logic [XW-1:0]        w_px, h_ln;

  assign w_px = (XW'(cfg.width) + XW'(1)) << UNIT_SH;
  assign h_ln = XW'(cfg.height) + XW'(1);

  for (genvar r = 0; r < GRID; r++) begin : g_row
    logic [XW-1:0] y0;
    logic          row_en;
    assign y0     = XW'(cfg.vstart) + XW'(r) * XW'(cfg.vdist);
    assign row_en = (IDXW'(r) <= cfg.rows);
    for (genvar c = 0; c < GRID; c++) begin : g_col
      logic [XW-1:0] x0;
      logic          en;
      assign x0 = (XW'(cfg.hstart) + XW'(cfg.hoff[IDXW*r +: IDXW])
                   + XW'(c) * XW'(cfg.hdist[FW*r +: FW])) << UNIT_SH;
      assign en = row_en && (IDXW'(c) <= cfg.hrep[IDXW*r +: IDXW]);
      pip_win_cell #(.XW(XW)) u_cell (
        .en(en), .px(px), .ln(ln), .x0(x0), .y0(y0),
        .w_px(w_px), .h_ln(h_ln), .hit(cell_hit[r*GRID + c])
      );
    end
  end

  pip_first_set #(.N(NWIN)) u_first (
    .vec(cell_hit), .any(hit), .idx(first)
  );

  assign row = first[2*IDXW-1:IDXW];
  assign col = first[IDXW-1:0];
endmodule

// File: rtl/pip_mosaic_gen.sv
module pip_mosaic_gen
  import pip_pkg::*;
#(
  parameter int HCW = 11,
  parameter int VCW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            field_start,
  input  logic [HCW-1:0]  h_cnt,
  input  logic [VCW-1:0]  v_cnt,
  input  logic [7:0]      main_hstart,
  input  logic [7:0]      main_vstart,
  input  logic [7:0]      main_width,
  input  logic [7:0]      main_height,
  input  logic [1:0]      main_rows,
  input  logic [7:0]      main_vdist,
  input  logic [7:0]      main_hrep,
  input  logic [7:0]      main_hoff,
  input  logic [31:0]     main_hdist,
  input  logic [7:0]      sub_hstart,
  input  logic [7:0]      sub_vstart,
  input  logic [7:0]      sub_width,
  input  logic [7:0]      sub_height,
  input  logic [1:0]      sub_rows,
  input  logic [7:0]      sub_vdist,
  input  logic [7:0]      sub_hrep,
  input  logic [7:0]      sub_hoff,
  input  logic [31:0]     sub_hdist,
  input  logic            prio_main,
  output logic            main_hit,
  output logic            sub_hit,
  output logic [1:0]      hit_row,
  output logic [1:0]      hit_col,
  output logic [1:0]      src_sel
);
  // internal coordinate width covers origin + offsets + spacing + size
  localparam int XW = 14;

  pip_cfg_t main_cfg_q, sub_cfg_q;
  logic     prio_q, loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_cfg_q <= '0;
      sub_cfg_q  <= '0;
      prio_q     <= 1'b0;
      loaded_q   <= 1'b0;
    end else if (field_start) begin
      main_cfg_q <= '{hstart: main_hstart, vstart: main_vstart,
                      width: main_width, height: main_height,
                      rows: main_rows, vdist: main_vdist,
                      hrep: main_hrep, hoff: main_hoff, hdist: main_hdist};
      sub_cfg_q  <= '{hstart: sub_hstart, vstart: sub_vstart,
                      width: sub_width, height: sub_height,
                      rows: sub_rows, vdist: sub_vdist,
                      hrep: sub_hrep, hoff: sub_hoff, hdist: sub_hdist};
      prio_q     <= prio_main;
      loaded_q   <= 1'b1;
    end
  end

  logic [XW-1:0]   px, ln;
  logic            m_hit, s_hit;
  logic [IDXW-1:0] m_row, m_col, s_row, s_col;

  assign px = XW'(h_cnt);
  assign ln = XW'(v_cnt);

  pip_channel #(.XW(XW)) u_main (
    .cfg(main_cfg_q), .px(px), .ln(ln),
    .hit(m_hit), .row(m_row), .col(m_col)
  );

  pip_channel #(.XW(XW)) u_sub (
    .cfg(sub_cfg_q), .px(px), .ln(ln),
    .hit(s_hit), .row(s_row), .col(s_col)
  );

  pip_src_e        src_d;
  logic [IDXW-1:0] row_d, col_d;
  logic            mh_d, sh_d;

  always_comb begin
    mh_d  = loaded_q && m_hit;
    sh_d  = loaded_q && s_hit;
    src_d = SRC_NONE;
    row_d = '0;
    col_d = '0;
    if (mh_d && (!sh_d || prio_q)) begin
      src_d = SRC_MAIN;
      row_d = m_row;
      col_d = m_col;
    end else if (sh_d) begin
      src_d = SRC_SUB;
      row_d = s_row;
      col_d = s_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_hit <= 1'b0;
      sub_hit  <= 1'b0;
      hit_row  <= '0;
      hit_col  <= '0;
      src_sel  <= SRC_NONE;
    end else begin
      main_hit <= mh_d;
      sub_hit  <= sh_d;
      hit_row  <= row_d;
      hit_col  <= col_d;
      src_sel  <= src_d;
    end
  end
endmodule

// File: rtl/pip_mosaic_sva.sv
module pip_mosaic_sva
  import pip_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     field_start,
  input logic     main_hit,
  input logic     sub_hit,
  input logic [1:0] hit_row,
  input logic [1:0] hit_col,
  input logic [1:0] src_sel,
  input logic     prio_q,
  input logic     loaded_q,
  input pip_cfg_t main_cfg_q,
  input pip_cfg_t sub_cfg_q
);
  // R1: nothing reported while no geometry has been loaded
  p_quiet_unloaded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(loaded_q) |-> (!main_hit && !sub_hit && src_sel == 2'b00));

  // R2: captured geometry only changes after a field-start cycle
  p_hold_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(field_start) |-> $stable(main_cfg_q));
  p_hold_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(field_start) |-> $stable(sub_cfg_q));

  // R10: selected source must actually have hit
  p_src_main_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b01) |-> main_hit);
  p_src_sub_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b10) |-> sub_hit);
  p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (main_hit && sub_hit) |-> (src_sel == ($past(prio_q) ? 2'b01 : 2'b10)));

  // R11: no hit means no source and zero indices
  p_idle_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_hit && !sub_hit) |-> (src_sel == 2'b00 && hit_row == 2'b00 && hit_col == 2'b00));
endmodule

bind pip_mosaic_gen pip_mosaic_sva u_sva (
  .clk(clk), .rst_n(rst_n), .field_start(field_start),
  .main_hit(main_hit), .sub_hit(sub_hit), .hit_row(hit_row),
  .hit_col(hit_col), .src_sel(src_sel), .prio_q(prio_q),
  .loaded_q(loaded_q), .main_cfg_q(main_cfg_q), .sub_cfg_q(sub_cfg_q)
);

// File: tb/pip_mosaic_gen_tb.sv
`timescale 1ns/1ps
module pip_mosaic_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        field_start = 1'b0;
  logic [10:0] h_cnt = '0;
  logic [9:0]  v_cnt = '0;
  logic [7:0]  main_hstart, main_vstart, main_width, main_height, main_vdist, main_hrep, main_hoff;
  logic [1:0]  main_rows;
  logic [31:0] main_hdist;
  logic [7:0]  sub_hstart, sub_vstart, sub_width, sub_height, sub_vdist, sub_hrep, sub_hoff;
  logic [1:0]  sub_rows;
  logic [31:0] sub_hdist;
  logic        prio_main;
  logic        main_hit, sub_hit;
  logic [1:0]  hit_row, hit_col, src_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pip_mosaic_gen u_dut (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .main_hstart(main_hstart), .main_vstart(main_vstart), .main_width(main_width),
    .main_height(main_height), .main_rows(main_rows), .main_vdist(main_vdist),
    .main_hrep(main_hrep), .main_hoff(main_hoff), .main_hdist(main_hdist),
    .sub_hstart(sub_hstart), .sub_vstart(sub_vstart), .sub_width(sub_width),
    .sub_height(sub_height), .sub_rows(sub_rows), .sub_vdist(sub_vdist),
    .sub_hrep(sub_hrep), .sub_hoff(sub_hoff), .sub_hdist(sub_hdist),
    .prio_main(prio_main), .main_hit(main_hit), .sub_hit(sub_hit),
    .hit_row(hit_row), .hit_col(hit_col), .src_sel(src_sel)
  );

  // packed view: {main_hit, sub_hit, src_sel, hit_row, hit_col}
  function automatic logic [7:0] pk(input logic m, input logic s, input logic [1:0] src,
                                    input logic [1:0] r, input logic [1:0] c);
    return {m, s, src, r, c};
  endfunction

  task automatic cmp(input logic [7:0] exp, input string req);
    logic [7:0] act;
    act = {main_hit, sub_hit, src_sel, hit_row, hit_col};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // drive a pixel, let one edge register it, sample at the next falling edge
  task automatic probe(input int h, input int v, input logic [7:0] exp, input string req);
    @(negedge clk);
    h_cnt = 11'(h);
    v_cnt = 10'(v);
    @(negedge clk);
    cmp(exp, req);
  endtask

  task automatic load();
    @(negedge clk);
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic base_cfg();
    main_hstart = 8'd10; main_vstart = 8'd20; main_width = 8'd1; main_height = 8'd2;
    main_rows = 2'd0; main_vdist = 8'd0; main_hrep = 8'd0; main_hoff = 8'd0; main_hdist = 32'd0;
    sub_hstart = 8'd250; sub_vstart = 8'd250; sub_width = 8'd0; sub_height = 8'd0;
    sub_rows = 2'd0; sub_vdist = 8'd0; sub_hrep = 8'd0; sub_hoff = 8'd0; sub_hdist = 32'd0;
    prio_main = 1'b0;
  endtask

  localparam logic [7:0] MISS = 8'h00;

  task automatic t_reset();
    cmp(MISS, "R1 reset value");
    probe(40, 20, MISS, "R1 no hit before first load");
  endtask

  task automatic t_single();
    load();
    probe(40, 20, pk(1, 0, 2'b01, 0, 0), "R3 left edge");
    probe(47, 22, pk(1, 0, 2'b01, 0, 0), "R4 bottom right corner");
    probe(48, 20, MISS, "R3 past right edge");
    probe(39, 20, MISS, "R3 before left edge");
    probe(40, 23, MISS, "R4 below last line");
    probe(40, 19, MISS, "R4 above first line");
    probe(1000, 250, pk(0, 1, 2'b10, 0, 0), "R10 sub only, minimum size");
    // R12: output still shows old pixel right after driving a new one
    @(negedge clk); h_cnt = 11'd40; v_cnt = 10'd20;
    @(negedge clk); h_cnt = 11'd48;
    #1 cmp(pk(1, 0, 2'b01, 0, 0), "R12 one cycle latency hold");
    @(negedge clk); cmp(MISS, "R12 one cycle latency update");
  endtask

  task automatic t_grid();
    main_rows = 2'd1; main_vdist = 8'd10;
    main_hrep = 8'b00_00_00_10;           // row0: 3 windows, row1: 1
    main_hoff = 8'b00_00_01_00;           // row1 offset 1 unit
    main_hdist = 32'h00_00_07_05;         // row0 spacing 5, row1 spacing 7
    load();
    probe(80, 21, pk(1, 0, 2'b01, 0, 2), "R8 row0 third window");
    probe(60, 20, pk(1, 0, 2'b01, 0, 1), "R6 row0 second window");
    probe(100, 20, MISS, "R6 row0 fourth window disabled");
    probe(44, 30, pk(1, 0, 2'b01, 1, 0), "R7 row1 offset start");
    probe(40, 30, MISS, "R7 row1 before offset");
    probe(72, 30, MISS, "R6 row1 second window disabled");
    probe(44, 40, MISS, "R5 row2 disabled");
  endtask

  task automatic t_self_overlap();
    main_rows = 2'd0; main_width = 8'd3;
    main_hrep = 8'b00_00_00_11; main_hoff = 8'd0; main_hdist = 32'h00_00_00_01;
    load();
    probe(48, 20, pk(1, 0, 2'b01, 0, 0), "R9 lowest column wins");
    probe(57, 20, pk(1, 0, 2'b01, 0, 1), "R9 second column when first ended");
  endtask

  task automatic t_priority();
    base_cfg();
    main_width = 8'd3;                    // main 40..55, lines 20..22
    sub_hstart = 8'd10; sub_vstart = 8'd20; sub_height = 8'd5;
    sub_hrep = 8'b00_00_00_01; sub_hdist = 32'h00_00_00_01;  // sub 40..43, 44..47
    prio_main = 1'b0;
    load();
    probe(45, 20, pk(1, 1, 2'b10, 0, 1), "R10 prio 0 sub on top, R11 sub index");
    probe(50, 20, pk(1, 0, 2'b01, 0, 0), "R10 main only");
    probe(45, 24, pk(0, 1, 2'b10, 0, 1), "R11 sub only index");
    prio_main = 1'b1;
    probe(45, 20, pk(1, 1, 2'b10, 0, 1), "R2 priority held until field start");
    load();
    probe(45, 20, pk(1, 1, 2'b01, 0, 0), "R10 prio 1 main on top, R11 main index");
  endtask

  task automatic t_reload();
    base_cfg();
    load();
    main_hstart = 8'd30;                  // new start pixel 120
    probe(40, 20, pk(1, 0, 2'b01, 0, 0), "R2 mid-field change ignored");
    @(negedge clk);
    field_start = 1'b1; h_cnt = 11'd40; v_cnt = 10'd20;
    @(negedge clk);
    field_start = 1'b0; h_cnt = 11'd120;
    cmp(pk(1, 0, 2'b01, 0, 0), "R2 capture cycle uses old geometry");
    @(negedge clk);
    cmp(pk(1, 0, 2'b01, 0, 0), "R2 new geometry next cycle");
    probe(40, 20, MISS, "R2 old position no longer hit");
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    base_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_grid();
    base_cfg();
    t_self_overlap();
    t_priority();
    t_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule